// File: doc/BRIEF.md
# Capture-Averaging Phase Trim Controller

This block keeps a free-running local timer aligned in phase with an external reference edge. Each time the reference edge arrives, the timer's count at that instant is presented as a capture sample. The block sums a block of twenty consecutive samples and takes the exact floor of the sum divided by twenty. It compares that average with a phase target equal to half the timer modulus, which is 150 for a modulus of 300. The sign of the difference moves a split point by a programmable step.

The split point governs a repeating frame of 1000 cycles, counted by an external cycle tick. Cycles whose index lies below the split select the fast oscillator trim code. The remaining cycles select the slow code. The oscillator's average frequency is therefore set finely by where the split sits. When the reference is clean, averaging can be bypassed so that each single capture drives the correction on its own. A dead-band input stops small errors from moving the split. A newly computed split is held back until the current frame ends.

Top module: `phase_trim_ctrl`

## Requirements
- R1: After reset the active split and the pending split are both 500, the frame index is 0, and `trim_fast` is 1.
- R2: With `avg_bypass` low, every 20 consecutive captures with `cap_valid` high form one block. The block's average is exactly floor(sum/20) for any 16-bit capture values.
- R3: The phase error is the average minus 150. A positive error raises the pending split by `step_size`, and a negative error lowers it by `step_size`.
- R4: When the magnitude of the error is at or below `dead_band`, the pending split is left unchanged.
- R5: The pending split saturates at 999 when raised and at 0 when lowered, and never wraps.
- R6: The frame index advances by one on each cycle with `cycle_tick` high and wraps from 999 to 0. `trim_fast` is 1 (fast code) while the index is below the active split and 0 (slow code) otherwise, so a frame holds exactly split-many fast cycles, all of them at its start.
- R7: The active split takes the pending value only when the index wraps from 999 to 0. An update made mid-frame does not change the frame in progress.
- R8: While `avg_bypass` is high, each capture is used directly as the average. The partial block sum and the capture count are cleared, so averaging restarts with a fresh block once bypass is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_valid | input | 1 | Capture sample strobe, one per reference edge |
| cap_value | input | 16 | Timer count captured at the reference edge |
| avg_bypass | input | 1 | Use each capture directly instead of averaging |
| step_size | input | 10 | Proportional correction step applied to the split |
| dead_band | input | 16 | Error magnitude at or below which no correction is made |
| cycle_tick | input | 1 | Advances the frame index by one |
| trim_fast | output | 1 | 1 selects the fast trim code, 0 the slow code |

## Verification
The only output is the trim select, so a wrong quotient, a wrong error sign, a misjudged dead band or a wrapped split shows up as the wrong number of fast cycles in the frame after the correction. That is up to one full frame, 1000 ticks, after the last capture of the block. A frame index that drifts without a tick, or that loads the split mid-frame, shows up in the same frame as a fast-cycle count that differs from the split, or as fast cycles after slow ones. Divider exactness is probed from both sides of each quotient, by setting the dead band equal to the expected error and then one below it, so an off-by-one quotient in either direction flips the decision.

// File: rtl/pt_pkg.sv
package pt_pkg;

   // Correction decision taken for one averaged error
   typedef enum logic [1:0] {
      ADJ_HOLD = 2'd0,
      ADJ_UP   = 2'd1,
      ADJ_DOWN = 2'd2
   } adj_e;

   function automatic int unsigned pt_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pt_div_const.sv
// Exact floor division of a block sum by the constant block length.
module pt_div_const #(
   parameter int CAP_W = 16,
   parameter int AVG_N = 20,
   localparam int LOG_N = $clog2(AVG_N),
   localparam int SUM_W = CAP_W + LOG_N
) (
   input  logic [SUM_W-1:0] sum_i,
   output logic [CAP_W-1:0] quot_o
);

   generate
      if ((1 << LOG_N) == AVG_N) begin : g_shift
         // Power-of-two block length: plain shift
         logic unused_low;
         assign unused_low = ^sum_i[LOG_N-1:0];
         assign quot_o     = sum_i[LOG_N +: CAP_W];
      end else begin : g_mulshift
         // Reciprocal with SUM_W + LOG_N fraction bits is exact for SUM_W-bit sums
         localparam int MAG_SH = SUM_W + LOG_N;
         localparam int MAG_W  = SUM_W + 1;
         localparam int PROD_W = SUM_W + MAG_W;
         localparam longint unsigned MAGIC =
            ((64'd1 << MAG_SH) + 64'(AVG_N) - 64'd1) / 64'(AVG_N);

         if (MAG_SH > 62) begin : g_bad_shift
            $error("pt_div_const: reciprocal shift too wide");
         end

         logic [MAG_W-1:0]  magic_c;
         logic [PROD_W-1:0] prod;
         logic              unused_prod;

         assign magic_c     = MAG_W'(MAGIC);
         assign prod        = PROD_W'(sum_i) * PROD_W'(magic_c);
         assign quot_o      = prod[MAG_SH +: CAP_W];
         assign unused_prod = ^{prod[PROD_W-1:MAG_SH+CAP_W], prod[MAG_SH-1:0]};
      end
   endgenerate

endmodule

// File: rtl/pt_capture_avg.sv
// Block accumulator with bypass; produces one average per block or per raw capture.
module pt_capture_avg #(
   parameter int CAP_W = 16,
   parameter int AVG_N = 20,
   localparam int LOG_N = $clog2(AVG_N),
   localparam int SUM_W = CAP_W + LOG_N,
   localparam int CNT_W = (LOG_N < 1) ? 1 : LOG_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_valid_i,
   input  logic [CAP_W-1:0] cap_value_i,
   input  logic             bypass_i,
   output logic [CAP_W-1:0] avg_o,
   output logic             avg_vld_o
);

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(AVG_N - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] acc_q;
   logic [SUM_W-1:0] blk_sum_q;
   logic             blk_vld_q;
   logic             blk_raw_q;
   logic [CAP_W-1:0] quot;
   logic [SUM_W-1:0] acc_next;

   assign acc_next = acc_q + SUM_W'(cap_value_i);

   // Stage 1: accumulate and close a block (or pass a raw capture)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         acc_q     <= '0;
         blk_sum_q <= '0;
         blk_vld_q <= 1'b0;
         blk_raw_q <= 1'b0;
      end else begin
         blk_vld_q <= 1'b0;
         if (bypass_i) begin
            cnt_q <= '0;
            acc_q <= '0;
            if (cap_valid_i) begin
               blk_sum_q <= SUM_W'(cap_value_i);
               blk_raw_q <= 1'b1;
               blk_vld_q <= 1'b1;
            end
         end else if (cap_valid_i) begin
            if (cnt_q == CNT_LAST) begin
               blk_sum_q <= acc_next;
               blk_raw_q <= 1'b0;
               blk_vld_q <= 1'b1;
               acc_q     <= '0;
               cnt_q     <= '0;
            end else begin
               acc_q <= acc_next;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   pt_div_const #(
      .CAP_W (CAP_W),
      .AVG_N (AVG_N)
   ) div_i (
      .sum_i  (blk_sum_q),
      .quot_o (quot)
   );

   // Stage 2: register the average
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avg_o     <= '0;
         avg_vld_o <= 1'b0;
      end else begin
         avg_vld_o <= blk_vld_q;
         if (blk_vld_q) begin
            avg_o <= blk_raw_q ? blk_sum_q[CAP_W-1:0] : quot;
         end
      end
   end

   // Divider bracket: quot*N <= sum < quot*N + N
   logic [SUM_W+1:0] q_times_n;
   assign q_times_n = (SUM_W+2)'(quot) * (SUM_W+2)'(AVG_N);

   // R2
   div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_vld_q && !blk_raw_q) |->
         (q_times_n <= (SUM_W+2)'(blk_sum_q)) &&
         ((SUM_W+2)'(blk_sum_q) < q_times_n + (SUM_W+2)'(AVG_N)));

   // R2
   blk_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST);

   // R8
   byp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_i |=> (cnt_q == '0) && (acc_q == '0));

endmodule

// File: rtl/pt_split_steer.sv
// Proportional steering of the pending split from the averaged phase error.
module pt_split_steer
   import pt_pkg::*;
#(
   parameter int CAP_W      = 16,
   parameter int TARGET     = 150,
   parameter int FRAME_LEN  = 1000,
   parameter int STEP_W     = 10,
   parameter int BAND_W     = 16,
   parameter int SPLIT_INIT = 500,
   localparam int SPLIT_W   = $clog2(FRAME_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAP_W-1:0]   avg_i,
   input  logic               avg_vld_i,
   input  logic [STEP_W-1:0]  step_i,
   input  logic [BAND_W-1:0]  band_i,
   output logic [SPLIT_W-1:0] pend_o
);

   localparam int ERR_W = CAP_W + 2;
   localparam int ACC_W = pt_max(SPLIT_W, STEP_W) + 2;
   localparam logic [SPLIT_W-1:0] SPLIT_LAST = SPLIT_W'(FRAME_LEN - 1);

   logic signed [ERR_W-1:0] err;
   logic signed [ERR_W-1:0] mag;
   adj_e                    adj;
   logic signed [ACC_W-1:0] up_v;
   logic signed [ACC_W-1:0] dn_v;
   logic [SPLIT_W-1:0]      pend_q;
   logic [SPLIT_W-1:0]      pend_n;

   always_comb begin
      err = $signed({2'b00, avg_i}) - $signed(ERR_W'(TARGET));
      mag = (err < 0) ? -err : err;
      if (mag > $signed(ERR_W'(band_i))) begin
         adj = (err > 0) ? ADJ_UP : ADJ_DOWN;
      end else begin
         adj = ADJ_HOLD;
      end
   end

   always_comb begin
      up_v = $signed(ACC_W'(pend_q)) + $signed(ACC_W'(step_i));
      dn_v = $signed(ACC_W'(pend_q)) - $signed(ACC_W'(step_i));
      unique case (adj)
         ADJ_UP:   pend_n = (up_v > $signed(ACC_W'(SPLIT_LAST))) ? SPLIT_LAST
                                                                : up_v[SPLIT_W-1:0];
         ADJ_DOWN: pend_n = (dn_v < 0) ? '0 : dn_v[SPLIT_W-1:0];
         default:  pend_n = pend_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= SPLIT_W'(SPLIT_INIT);
      end else if (avg_vld_i) begin
         pend_q <= pend_n;
      end
   end

   assign pend_o = pend_q;

   // R5
   split_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= SPLIT_LAST);

   // R4
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_vld_i && (mag <= $signed(ERR_W'(band_i)))) |=> $stable(pend_q));

   // R3
   dir_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_vld_i && (err > 0)) |=> (pend_q >= $past(pend_q)));

   // R3
   dir_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_vld_i && (err < 0)) |=> (pend_q <= $past(pend_q)));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !avg_vld_i |=> $stable(pend_q));

endmodule

// File: rtl/pt_trim_frame.sv
// Frame index counter and fast/slow trim selection from the active split.
module pt_trim_frame #(
   parameter int FRAME_LEN  = 1000,
   parameter int SPLIT_INIT = 500,
   localparam int SPLIT_W   = $clog2(FRAME_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic [SPLIT_W-1:0] pend_i,
   output logic               fast_o
);

   localparam logic [SPLIT_W-1:0] IDX_LAST = SPLIT_W'(FRAME_LEN - 1);

   logic [SPLIT_W-1:0] idx_q;
   logic [SPLIT_W-1:0] act_q;
   logic               wrap;

   assign wrap = tick_i && (idx_q == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         act_q <= SPLIT_W'(SPLIT_INIT);
      end else if (tick_i) begin
         if (wrap) begin
            idx_q <= '0;
            act_q <= pend_i;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign fast_o = (idx_q < act_q);

   // R6
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(idx_q));

   // R6
   idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (idx_q == '0));

   // R7
   split_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act_q));

endmodule

// File: rtl/phase_trim_ctrl.sv
module phase_trim_ctrl #(
   parameter int CAP_W      = 16,
   parameter int MODULUS    = 300,
   parameter int AVG_N      = 20,
   parameter int FRAME_LEN  = 1000,
   parameter int STEP_W     = 10,
   parameter int BAND_W     = 16,
   parameter int SPLIT_INIT = FRAME_LEN / 2,
   localparam int TARGET    = MODULUS / 2,
   localparam int SPLIT_W   = $clog2(FRAME_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_valid,
   input  logic [CAP_W-1:0]  cap_value,
   input  logic              avg_bypass,
   input  logic [STEP_W-1:0] step_size,
   input  logic [BAND_W-1:0] dead_band,
   input  logic              cycle_tick,
   output logic              trim_fast
);

   // Elaboration-time parameter checks
   generate
      if (AVG_N < 2) begin : g_bad_avg
         $error("phase_trim_ctrl: AVG_N must be at least 2");
      end
      if (FRAME_LEN < 2) begin : g_bad_frame
         $error("phase_trim_ctrl: FRAME_LEN must be at least 2");
      end
      if ((SPLIT_INIT < 0) || (SPLIT_INIT >= FRAME_LEN)) begin : g_bad_init
         $error("phase_trim_ctrl: SPLIT_INIT outside the frame");
      end
      if (TARGET >= (1 << CAP_W)) begin : g_bad_target
         $error("phase_trim_ctrl: phase target exceeds capture range");
      end
      if (BAND_W > CAP_W + 1) begin : g_bad_band
         $error("phase_trim_ctrl: BAND_W wider than the error magnitude");
      end
   endgenerate

   logic [CAP_W-1:0]   avg;
   logic               avg_vld;
   logic [SPLIT_W-1:0] pend;

   pt_capture_avg #(
      .CAP_W (CAP_W),
      .AVG_N (AVG_N)
   ) avg_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_valid_i (cap_valid),
      .cap_value_i (cap_value),
      .bypass_i    (avg_bypass),
      .avg_o       (avg),
      .avg_vld_o   (avg_vld)
   );

   pt_split_steer #(
      .CAP_W      (CAP_W),
      .TARGET     (TARGET),
      .FRAME_LEN  (FRAME_LEN),
      .STEP_W     (STEP_W),
      .BAND_W     (BAND_W),
      .SPLIT_INIT (SPLIT_INIT)
   ) steer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .avg_i     (avg),
      .avg_vld_i (avg_vld),
      .step_i    (step_size),
      .band_i    (dead_band),
      .pend_o    (pend)
   );

   pt_trim_frame #(
      .FRAME_LEN  (FRAME_LEN),
      .SPLIT_INIT (SPLIT_INIT)
   ) frame_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (cycle_tick),
      .pend_i (pend),
      .fast_o (trim_fast)
   );

endmodule

// File: tb/phase_trim_ctrl_tb_top.sv
`timescale 1ns/1ps
module phase_trim_ctrl_tb_top;

   localparam int NB = 20;     // captures per block
   localparam int TGT = 150;   // half of modulus 300
   localparam int FLEN = 1000; // frame length

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_valid = 1'b0;
   logic [15:0] cap_value = '0;
   logic        avg_bypass = 1'b0;
   logic [9:0]  step_size = '0;
   logic [15:0] dead_band = '0;
   logic        cycle_tick = 1'b0;
   logic        trim_fast;

   int n_tests = 0;
   int n_fail  = 0;
   int exp_act = 500;
   int exp_pend = 500;
   int fcount = 0;
   bit seen_slow = 1'b0;
   bit shape_bad = 1'b0;

   always #5 clk = ~clk;

   phase_trim_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_valid  (cap_valid),
      .cap_value  (cap_value),
      .avg_bypass (avg_bypass),
      .step_size  (step_size),
      .dead_band  (dead_band),
      .cycle_tick (cycle_tick),
      .trim_fast  (trim_fast)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // Reference model of one correction
   task automatic model(input int q, input int db, input int st);
      int err;
      err = q - TGT;
      if (err > db) exp_pend = (exp_pend + st > FLEN - 1) ? FLEN - 1 : exp_pend + st;
      else if (-err > db) exp_pend = (exp_pend - st < 0) ? 0 : exp_pend - st;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (trim_fast) begin
            fcount++;
            if (seen_slow) shape_bad = 1'b1;
         end else begin
            seen_slow = 1'b1;
         end
         cycle_tick = 1'b1;
      end
      @(negedge clk);
      cycle_tick = 1'b0;
   endtask

   task automatic frame_begin();
      fcount = 0;
      seen_slow = 1'b0;
      shape_bad = 1'b0;
   endtask

   task automatic frame_end(input string tag);
      chk(fcount == exp_act, tag, fcount, exp_act);
      chk(!shape_bad, "R6 fast cycles lead the frame", int'(shape_bad), 0);
      exp_act = exp_pend;
   endtask

   task automatic frame_check(input string tag);
      frame_begin();
      ticks(FLEN);
      frame_end(tag);
   endtask

   // One averaged block whose sum is s; captures spread around the mean
   task automatic apply_block(input int s, input int db, input int st);
      int base, rem, v;
      base = s / NB;
      rem  = s % NB;
      dead_band = 16'(db);
      step_size = 10'(st);
      avg_bypass = 1'b0;
      for (int i = 0; i < NB; i++) begin
         if (base >= 7 && base <= 65535 - 27) begin
            if (i == NB - 1) v = base + 7 + rem;
            else v = (i % 2 == 1) ? base + 7 : base - 7;
         end else begin
            v = (i == NB - 1) ? base + rem : base;
         end
         @(negedge clk);
         cap_valid = 1'b1;
         cap_value = 16'(v);
      end
      @(negedge clk);
      cap_valid = 1'b0;
      repeat (4) @(negedge clk);
      model(s / NB, db, st);
   endtask

   task automatic apply_raw(input int v, input int db, input int st);
      dead_band = 16'(db);
      step_size = 10'(st);
      @(negedge clk);
      avg_bypass = 1'b1;
      cap_valid  = 1'b1;
      cap_value  = 16'(v);
      @(negedge clk);
      cap_valid  = 1'b0;
      repeat (4) @(negedge clk);
      avg_bypass = 1'b0;
      model(v, db, st);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      int qs [11];
      int q, r, mag;
      qs = '{151, 160, 149, 100, 1000, 40000, 65535, 0, 7, 300, 12345};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, index 0 below split 500
      chk(trim_fast == 1'b1, "R1 trim_fast after reset", int'(trim_fast), 1);
      frame_check("R1 R6 reset split frame");

      // R2 R3: quotient boundaries around the target, no dead band
      apply_block(2999, 0, 3); frame_check("R2 R3 sum 2999");
      apply_block(3000, 0, 3); frame_check("R2 R3 sum 3000");
      apply_block(3019, 0, 3); frame_check("R2 R3 sum 3019");
      apply_block(3020, 0, 3); frame_check("R2 R3 sum 3020");
      apply_block(3039, 0, 3); frame_check("R2 R3 sum 3039");
      apply_block(2980, 0, 3); frame_check("R2 R3 sum 2980");

      // R2 R4: dead band equal to the error, then one below, across the range
      for (int j = 0; j < 11; j++) begin
         q = qs[j];
         r = (q == 65535) ? 0 : (j * 7) % NB;
         mag = (q > TGT) ? q - TGT : TGT - q;
         apply_block(q * NB + r, mag, 5);
         frame_check("R2 R4 band at error");
         apply_block(q * NB + r, mag - 1, 5);
         frame_check("R2 R4 band below error");
      end

      // R5: saturation at both ends
      apply_block(1000 * NB, 0, 700); frame_check("R5 raise");
      apply_block(1000 * NB, 0, 700); frame_check("R5 raise");
      apply_block(1000 * NB, 0, 700); frame_check("R5 hold at 999");
      apply_block(0, 0, 700);         frame_check("R5 lower");
      apply_block(0, 0, 700);         frame_check("R5 lower");
      apply_block(5 * NB + 3, 0, 700); frame_check("R5 hold at 0");
      frame_check("R5 split 0 frame");

      // R7: update mid-frame, idle clocks without ticks in between (R6)
      frame_begin();
      ticks(300);
      apply_block(400 * NB + 11, 0, 250);
      ticks(700);
      frame_end("R7 mid-frame update deferred");
      frame_check("R7 update applied next frame");

      // R8: bypass uses single captures directly
      apply_raw(160, 5, 20); frame_check("R8 raw 160");
      apply_raw(153, 5, 20); frame_check("R8 raw 153 in band");
      apply_raw(120, 5, 20); frame_check("R8 raw 120");

      // R8: partial block discarded by bypass
      dead_band = 16'd0;
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         cap_valid = 1'b1;
         cap_value = 16'd0;
      end
      @(negedge clk);
      cap_valid  = 1'b0;
      avg_bypass = 1'b1;
      repeat (2) @(negedge clk);
      avg_bypass = 1'b0;
      apply_block(170 * NB, 0, 20); frame_check("R8 fresh block after bypass");
      frame_check("R8 final split");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule